// File: doc/BRIEF.md
# Multi-Set Streaming Sum Reducer

The reducer folds a stream of integer values into one sum per set. Values arrive at most one per clock cycle. Each value carries a set tag and a flag that marks the final value of its set. Sets follow each other with no gap, and each set may have any length. Every addition goes through a single adder with `ALPHA` pipeline stages. Partial results re-enter that adder as they emerge, so one set can still be draining while the next set is already streaming in.

Values that cannot be paired in the current cycle wait in a small associative store. Each cycle a greedy pairing step picks at most one same-set pair for the adder. A per-tag table counts the live values of each set and records whether its final value has been seen. When a set is down to a single value and its final flag has arrived, that value is emitted on the output with the set's tag. The upstream source must not reuse a tag until the earlier set with that tag has been emitted.

Top module: `rdc_reducer`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0. Values taken before a reset never contribute to a sum emitted after it.
- R2: The unit accepts a value on every cycle in which `in_valid` is 1, with no back-pressure signal of any kind.
- R3: Each emitted `out_value` equals the sum of all values of its set, modulo 2^W.
- R4: Each set is emitted exactly once. `out_set` equals the `in_set` tag its values carried.
- R5: A set of one value is emitted with that value unchanged. When no adder result completes in the same cycle, `out_valid` rises one cycle after the value is taken.
- R6: No addition ever combines values of two different sets. Every operand pair issued to the adder belongs to one set that has at least two live values.
- R7: For p sets sent back to back with s_i values in total, the last sum is on the output no later than sum(s_i) + 2·ALPHA² + 2 cycles after the first value is driven.
- R8: The pending-value store never has to accept more values than it has free slots. Every result that leaves the adder belongs to a set with a nonzero live count.
- R9: Idle cycles (`in_valid` = 0) may appear inside a set or between sets without changing any result.
- R10: A two-value set alone in the unit is emitted exactly ALPHA+1 cycles after its second value is driven.
- R11: A set may begin while the sums of earlier sets are still in the adder. Sets of different lengths in any order all reduce correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A value is presented this cycle |
| in_value | input | W | Value to accumulate |
| in_set | input | SW | Tag of the set the value belongs to |
| in_last | input | 1 | This value is the final one of its set |
| out_valid | output | 1 | A finished set sum is presented this cycle |
| out_value | output | W | Sum of the finished set |
| out_set | output | SW | Tag of the finished set |

## Verification
Some properties are checked on every cycle by assertions: the output stays quiet under reset, the store never overflows, each adder result maps to a live set, and every issued pair belongs to a set that holds two live values. Other behaviour only shows up in the bench's scenarios. These are the correctness of the wrapped sums, one emission per set, the bypass and two-value latencies, and the completion bound. The bench sweeps all pairs of set lengths from 1 to 7 and all triples from 1 to 3, then adds a long back-to-back stream, a gapped stream, a long wrapping set and a reset in the middle of a set.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;
  // which operands feed the adder this cycle
  typedef enum logic [2:0] {
    ISS_NONE,
    ISS_RES_IN,   // adder result + incoming value
    ISS_RES_BUF,  // adder result + stored value
    ISS_IN_BUF,   // incoming value + stored value
    ISS_BUF_BUF   // two stored values
  } iss_src_e;

  // which finished value goes to the output register
  typedef enum logic [1:0] {
    EM_NONE,
    EM_RES,
    EM_IN,
    EM_BUF
  } emit_src_e;
endpackage

// File: rtl/rdc_add_pipe.sv
`timescale 1ns/1ps
module rdc_add_pipe #(
  parameter int W      = 16,
  parameter int SW     = 4,
  parameter int STAGES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [SW-1:0] in_set,
  output logic          out_v,
  output logic [W-1:0]  out_sum,
  output logic [SW-1:0] out_set
);
  logic          v_q   [STAGES];
  logic [W-1:0]  sum_q [STAGES];
  logic [SW-1:0] tag_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) v_q[0] <= 1'b0;
          else        v_q[0] <= in_v;
        end
        always_ff @(posedge clk) begin
          if (in_v) begin
            sum_q[0] <= in_a + in_b;
            tag_q[0] <= in_set;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) v_q[g] <= 1'b0;
          else        v_q[g] <= v_q[g-1];
        end
        always_ff @(posedge clk) begin
          if (v_q[g-1]) begin
            sum_q[g] <= sum_q[g-1];
            tag_q[g] <= tag_q[g-1];
          end
        end
      end
    end
  endgenerate

  assign out_v   = v_q[STAGES-1];
  assign out_sum = sum_q[STAGES-1];
  assign out_set = tag_q[STAGES-1];
endmodule

// File: rtl/rdc_store.sv
`timescale 1ns/1ps
module rdc_store #(
  parameter int W     = 16,
  parameter int SW    = 4,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DEPTH-1:0]           clr,
  input  logic                       p0_v,
  input  logic [W-1:0]               p0_val,
  input  logic [SW-1:0]              p0_set,
  input  logic                       p1_v,
  input  logic [W-1:0]               p1_val,
  input  logic [SW-1:0]              p1_set,
  output logic [DEPTH-1:0]           ent_v,
  output logic [DEPTH-1:0][W-1:0]    ent_val,
  output logic [DEPTH-1:0][SW-1:0]   ent_set,
  output logic                       ovf
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0]    f0, f1;
  logic             has0, has1;
  logic [DEPTH-1:0] v_n;
  logic             w0, w1;

  // two lowest free slots of the current occupancy
  always_comb begin
    has0 = 1'b0;
    has1 = 1'b0;
    f0   = '0;
    f1   = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (!ent_v[j]) begin
        if (!has0) begin
          has0 = 1'b1;
          f0   = IW'(j);
        end else if (!has1) begin
          has1 = 1'b1;
          f1   = IW'(j);
        end
      end
    end
  end

  always_comb begin
    w0  = p0_v && has0;
    w1  = p1_v && has1;
    ovf = (p0_v && !has0) || (p1_v && !has1);
    v_n = ent_v & ~clr;
    if (w0) v_n[f0] = 1'b1;
    if (w1) v_n[f1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_v <= '0;
    else        ent_v <= v_n;
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      if (w0 && (f0 == IW'(j))) begin
        ent_val[j] <= p0_val;
        ent_set[j] <= p0_set;
      end else if (w1 && (f1 == IW'(j))) begin
        ent_val[j] <= p1_val;
        ent_set[j] <= p1_set;
      end
    end
  end
endmodule

// File: rtl/rdc_set_table.sv
`timescale 1ns/1ps
module rdc_set_table #(
  parameter int SW = 4,
  parameter int CW = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inc_v,
  input  logic [SW-1:0]                  inc_set,
  input  logic                           inc_last,
  input  logic                           dec_v,
  input  logic [SW-1:0]                  dec_set,
  input  logic                           emit_v,
  input  logic [SW-1:0]                  emit_set,
  output logic [(1<<SW)-1:0][CW-1:0]     cnt_vec,
  output logic [(1<<SW)-1:0]             done_vec
);
  localparam int NSET = 1 << SW;

  generate
    for (genvar g = 0; g < NSET; g++) begin : g_tag
      logic          hit_in, hit_dec, hit_em;
      logic [CW-1:0] cnt_n;
      logic          done_n;

      always_comb begin
        hit_in  = inc_v  && (inc_set  == SW'(g));
        hit_dec = dec_v  && (dec_set  == SW'(g));
        hit_em  = emit_v && (emit_set == SW'(g));
        cnt_n   = cnt_vec[g] + CW'(hit_in) - CW'(hit_dec) - CW'(hit_em);
        done_n  = (done_vec[g] | (hit_in & inc_last)) & ~hit_em;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_vec[g]  <= '0;
          done_vec[g] <= 1'b0;
        end else begin
          cnt_vec[g]  <= cnt_n;
          done_vec[g] <= done_n;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rdc_reducer.sv
`timescale 1ns/1ps
module rdc_reducer
  import rdc_pkg::*;
#(
  parameter int W     = 16,
  parameter int SW    = 4,
  parameter int ALPHA = 4,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_value,
  input  logic [SW-1:0] in_set,
  input  logic          in_last,
  output logic          out_valid,
  output logic [W-1:0]  out_value,
  output logic [SW-1:0] out_set
);
  localparam int NSET = 1 << SW;
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + ALPHA + 2) + 1;

  // reset: asserted asynchronously, released on the clock
  logic rs_q1, rs_q2, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i_n = rs_q2;

  // adder pipeline
  logic          iss_v;
  logic [W-1:0]  iss_a, iss_b;
  logic [SW-1:0] iss_set;
  logic          res_v;
  logic [W-1:0]  res_val;
  logic [SW-1:0] res_set;

  rdc_add_pipe #(.W(W), .SW(SW), .STAGES(ALPHA)) u_add (
    .clk(clk), .rst_n(rst_i_n),
    .in_v(iss_v), .in_a(iss_a), .in_b(iss_b), .in_set(iss_set),
    .out_v(res_v), .out_sum(res_val), .out_set(res_set)
  );

  // pending store
  logic [DEPTH-1:0]         st_clr;
  logic                     p0_v, p1_v;
  logic [W-1:0]             p0_val, p1_val;
  logic [SW-1:0]            p0_set, p1_set;
  logic [DEPTH-1:0]         ent_v;
  logic [DEPTH-1:0][W-1:0]  ent_val;
  logic [DEPTH-1:0][SW-1:0] ent_set;
  logic                     st_ovf;

  rdc_store #(.W(W), .SW(SW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_i_n), .clr(st_clr),
    .p0_v(p0_v), .p0_val(p0_val), .p0_set(p0_set),
    .p1_v(p1_v), .p1_val(p1_val), .p1_set(p1_set),
    .ent_v(ent_v), .ent_val(ent_val), .ent_set(ent_set), .ovf(st_ovf)
  );

  // per-tag live count and final-seen flag
  emit_src_e               em;
  logic                    em_v;
  logic [SW-1:0]           em_set;
  logic [W-1:0]            em_val;
  logic [NSET-1:0][CW-1:0] cnt_vec;
  logic [NSET-1:0]         done_vec;

  rdc_set_table #(.SW(SW), .CW(CW)) u_tab (
    .clk(clk), .rst_n(rst_i_n),
    .inc_v(in_valid), .inc_set(in_set), .inc_last(in_last),
    .dec_v(iss_v), .dec_set(iss_set),
    .emit_v(em_v), .emit_set(em_set),
    .cnt_vec(cnt_vec), .done_vec(done_vec)
  );

  // classification of the candidates
  logic             r_done_eff, r_fin, i_fin, r_cand, i_cand;
  logic [CW:0]      r_cnt_eff;
  logic [DEPTH-1:0] b_fin, rm, im;
  logic             any_bf, any_rm, any_im, bb_found;
  logic [IW-1:0]    bf_idx, rm_idx, im_idx, bb_j, bb_k;

  always_comb begin
    r_done_eff = done_vec[res_set] | (in_valid & in_last & (in_set == res_set));
    r_cnt_eff  = {1'b0, cnt_vec[res_set]} + (CW+1)'(in_valid && (in_set == res_set));
    r_fin      = res_v & r_done_eff & (r_cnt_eff == (CW+1)'(1));
    i_fin      = in_valid & in_last & (cnt_vec[in_set] == '0);
    r_cand     = res_v & ~r_fin;
    i_cand     = in_valid & ~i_fin;
    for (int j = 0; j < DEPTH; j++) begin
      b_fin[j] = ent_v[j] & done_vec[ent_set[j]] & (cnt_vec[ent_set[j]] == CW'(1));
      rm[j]    = ent_v[j] & ~b_fin[j] & (ent_set[j] == res_set);
      im[j]    = ent_v[j] & ~b_fin[j] & (ent_set[j] == in_set);
    end
    any_bf = |b_fin;
    any_rm = |rm;
    any_im = |im;
    bf_idx = '0;
    rm_idx = '0;
    im_idx = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (b_fin[j]) bf_idx = IW'(j);
      if (rm[j])    rm_idx = IW'(j);
      if (im[j])    im_idx = IW'(j);
    end
  end

  // lowest pair of stored values sharing a tag
  always_comb begin
    bb_found = 1'b0;
    bb_j     = '0;
    bb_k     = '0;
    for (int j = 0; j < DEPTH; j++) begin
      for (int k = j + 1; k < DEPTH; k++) begin
        if (!bb_found && ent_v[j] && ent_v[k] && !b_fin[j] && !b_fin[k] &&
            (ent_set[j] == ent_set[k])) begin
          bb_found = 1'b1;
          bb_j     = IW'(j);
          bb_k     = IW'(k);
        end
      end
    end
  end

  // issue, emit and push decisions
  iss_src_e iss;
  logic     r_push, i_push;

  always_comb begin
    if (r_cand && i_cand && (res_set == in_set)) iss = ISS_RES_IN;
    else if (r_cand && any_rm)                   iss = ISS_RES_BUF;
    else if (i_cand && any_im)                   iss = ISS_IN_BUF;
    else if (bb_found)                           iss = ISS_BUF_BUF;
    else                                         iss = ISS_NONE;

    if (r_fin)       em = EM_RES;
    else if (i_fin)  em = EM_IN;
    else if (any_bf) em = EM_BUF;
    else             em = EM_NONE;
    em_v = (em != EM_NONE);

    unique case (em)
      EM_RES:  begin em_set = res_set;          em_val = res_val;          end
      EM_IN:   begin em_set = in_set;           em_val = in_value;         end
      EM_BUF:  begin em_set = ent_set[bf_idx];  em_val = ent_val[bf_idx];  end
      default: begin em_set = '0;               em_val = '0;               end
    endcase

    iss_v   = (iss != ISS_NONE);
    iss_a   = '0;
    iss_b   = '0;
    iss_set = '0;
    st_clr  = '0;
    unique case (iss)
      ISS_RES_IN:  begin iss_a = res_val;  iss_b = in_value;        iss_set = res_set; end
      ISS_RES_BUF: begin iss_a = res_val;  iss_b = ent_val[rm_idx]; iss_set = res_set;
                         st_clr[rm_idx] = 1'b1; end
      ISS_IN_BUF:  begin iss_a = in_value; iss_b = ent_val[im_idx]; iss_set = in_set;
                         st_clr[im_idx] = 1'b1; end
      ISS_BUF_BUF: begin iss_a = ent_val[bb_j]; iss_b = ent_val[bb_k]; iss_set = ent_set[bb_j];
                         st_clr[bb_j] = 1'b1; st_clr[bb_k] = 1'b1; end
      default: ;
    endcase
    if (em == EM_BUF) st_clr[bf_idx] = 1'b1;

    r_push = r_cand && (iss != ISS_RES_IN) && (iss != ISS_RES_BUF);
    i_push = (i_cand && (iss != ISS_RES_IN) && (iss != ISS_IN_BUF)) ||
             (i_fin && (em != EM_IN));

    p0_v   = r_push | i_push;
    p0_val = r_push ? res_val : in_value;
    p0_set = r_push ? res_set : in_set;
    p1_v   = r_push & i_push;
    p1_val = in_value;
    p1_set = in_set;
  end

  // output register
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) out_valid <= 1'b0;
    else          out_valid <= em_v;
  end

  always_ff @(posedge clk) begin
    if (em_v) begin
      out_value <= em_val;
      out_set   <= em_set;
    end
  end
endmodule

// File: rtl/rdc_reducer_chk.sv
`timescale 1ns/1ps
module rdc_reducer_chk #(
  parameter int SW = 4,
  parameter int CW = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       out_valid,
  input logic                       ovf,
  input logic                       r_v,
  input logic [SW-1:0]              r_set,
  input logic                       iss_v,
  input logic [SW-1:0]              iss_set,
  input logic                       in_valid,
  input logic [SW-1:0]              in_set,
  input logic [(1<<SW)-1:0][CW-1:0] cnt_vec
);
  // R1: output held quiet while reset is applied
  p_quiet_in_reset_r1: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R8: the pending store always has room for what is pushed
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n) !ovf);

  // R8: an adder result always belongs to a set still counted as live
  p_result_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    r_v |-> (cnt_vec[r_set] != '0));

  // R6: an issued pair draws on two live values of one set
  p_pair_same_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_v |-> (({1'b0, cnt_vec[iss_set]} + (CW+1)'(in_valid && (in_set == iss_set)))
               >= (CW+1)'(2)));
endmodule

bind rdc_reducer rdc_reducer_chk #(.SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .ovf(st_ovf),
  .r_v(res_v), .r_set(res_set), .iss_v(iss_v), .iss_set(iss_set),
  .in_valid(in_valid), .in_set(in_set), .cnt_vec(cnt_vec)
);

// File: tb/rdc_reducer_test.sv
`timescale 1ns/1ps
module rdc_reducer_test;
  localparam int W  = 16;
  localparam int SW = 4;
  localparam int A  = 4;
  localparam int D  = 16;
  localparam int NS = 1 << SW;
  localparam int MAXS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_value = '0;
  logic [SW-1:0] in_set = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic [W-1:0]  out_value;
  logic [SW-1:0] out_set;

  always #2.5 clk = ~clk;

  rdc_reducer #(.W(W), .SW(SW), .ALPHA(A), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_set(in_set), .in_last(in_last), .out_valid(out_valid),
    .out_value(out_value), .out_set(out_set)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int nsets = 0;
  int salt = 0;
  logic [W-1:0] exp_sum [MAXS];
  int got [MAXS];
  int ended [MAXS];
  int lastin [MAXS];
  int outc [MAXS];
  int sizes [MAXS];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] val_of(int i, int j);
    return W'((i * 4099 + j * 977 + salt * 311 + 12345) * 7);
  endfunction

  // output monitor: R3 value, R4 one emission per set
  always @(negedge clk) begin
    int k;
    k = -1;
    if (rst_n && out_valid) begin
      for (int i = 0; i < nsets; i++)
        if (k < 0 && (i % NS) == int'(out_set) && ended[i] != 0 && got[i] == 0) k = i;
      checks++;
      if (k < 0) begin
        fails++;
        $display("FAIL R4: unexpected sum for tag %0d value %h (expected no output)", out_set, out_value);
      end else begin
        got[k]  = 1;
        outc[k] = cyc;
        if (out_value !== exp_sum[k]) begin
          fails++;
          $display("FAIL R3: set %0d sum %h expected %h", k, out_value, exp_sum[k]);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // drive sets 0..n-1 using sizes[], optional idle cycles; then check R4 and R7
  task automatic run_sets(int n, int gaps);
    int first;
    int total;
    int last_out;
    int all;
    first = -1;
    total = 0;
    for (int i = 0; i < n; i++) begin
      exp_sum[i] = '0;
      got[i] = 0;
      ended[i] = 0;
      outc[i] = 0;
    end
    nsets = n;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < sizes[i]; j++) begin
        if (gaps != 0 && ((i + j) % 3) == 1) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_value = val_of(i, j);
        in_set   = SW'(i % NS);
        in_last  = (j == sizes[i] - 1);
        exp_sum[i] = exp_sum[i] + val_of(i, j);
        if (first < 0) first = cyc;
        total++;
        if (j == sizes[i] - 1) begin
          ended[i]  = 1;
          lastin[i] = cyc;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int t = 0; t < 800; t++) begin
      all = 1;
      for (int i = 0; i < n; i++) if (got[i] == 0) all = 0;
      if (all != 0) break;
      @(negedge clk);
    end
    repeat (12) @(negedge clk);
    all = 1;
    last_out = 0;
    for (int i = 0; i < n; i++) begin
      if (got[i] == 0) all = 0;
      if (outc[i] > last_out) last_out = outc[i];
    end
    checks++;
    if (all == 0) begin
      fails++;
      $display("FAIL R4: not every set emitted (actual missing, expected all %0d)", n);
    end
    if (gaps == 0) begin
      checks++;  // R7 completion bound
      if (last_out - first > total + 2 * A * A + 2) begin
        fails++;
        $display("FAIL R7: completion took %0d cycles expected <= %0d",
                 last_out - first, total + 2 * A * A + 2);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;  // R1
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid %b after reset expected 0", out_valid);
    end

    // R5: single value passes unchanged, one cycle later
    salt = 1;
    sizes[0] = 1;
    run_sets(1, 0);
    checks++;
    if (outc[0] - lastin[0] != 1) begin
      fails++;
      $display("FAIL R5: bypass latency %0d expected 1", outc[0] - lastin[0]);
    end

    // R10: isolated two-value set latency
    salt = 2;
    sizes[0] = 2;
    run_sets(1, 0);
    checks++;
    if (outc[0] - lastin[0] != A + 1) begin
      fails++;
      $display("FAIL R10: pair latency %0d expected %0d", outc[0] - lastin[0], A + 1);
    end

    // R11/R2: every ordered pair of lengths 1..7 back to back
    for (int a = 1; a <= 7; a++) begin
      for (int b = 1; b <= 7; b++) begin
        salt = a * 8 + b;
        sizes[0] = a;
        sizes[1] = b;
        run_sets(2, 0);
      end
    end

    // R11: every triple of lengths 1..3
    for (int a = 1; a <= 3; a++)
      for (int b = 1; b <= 3; b++)
        for (int c = 1; c <= 3; c++) begin
          salt = 100 + a * 9 + b * 3 + c;
          sizes[0] = a;
          sizes[1] = b;
          sizes[2] = c;
          run_sets(3, 0);
        end

    // R2/R7: long back-to-back stream reusing tags
    salt = 200;
    for (int i = 0; i < 48; i++) sizes[i] = ((i * 5 + 3) % 9) + 1;
    run_sets(48, 0);

    // R9: idle cycles inside and between sets
    salt = 300;
    for (int i = 0; i < 30; i++) sizes[i] = ((i * 7 + 2) % 6) + 1;
    run_sets(30, 1);

    // R3: one long set whose sum wraps
    salt = 400;
    sizes[0] = 150;
    run_sets(1, 0);

    // R1: values taken before a reset never reach a later sum
    nsets = 0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_value = 16'h1111;
      in_set   = '0;
      in_last  = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    do_reset();
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid %b after mid-set reset expected 0", out_valid);
    end
    salt = 500;
    sizes[0] = 3;
    run_sets(1, 0);  // R1: sum must hold only the fresh values

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule